// File: doc/BRIEF.md
# Prioritised Dual-Writer Register Port

This block is a bank of 16-bit configuration registers with two writers. User logic reaches the bank through a select, write-enable, address and data port. It gets read data back one cycle after a read, and it sees a ready flag. An internal calibration engine can write the same registers through a second write-only port. When both write in the same cycle, the calibration engine wins.

A user write that is displaced is not lost. It is parked in a single-entry holding store, and the ready flag drops. Once the calibration engine has stopped issuing writes and its last write has landed, the parked write is replayed and the ready flag rises again. User writes presented while the flag is low are discarded.

Reserved bit positions are hardwired to zero, so a read-modify-write from software leaves them intact. Addresses beyond the implemented registers read as zero and ignore writes.

Top module: `rp_reg_port`

## Requirements
- R1: After synchronous reset every register holds zero, the read data output is zero and the ready flag is high.
- R2: A read is a clock edge with `usr_sel` high and `usr_we` low. The register value appears on `usr_rdata` after that edge. At edges without a read, `usr_rdata` keeps its value. Reads are served whether or not the ready flag is high.
- R3: An accepted user write (`usr_sel`, `usr_we` and ready all high at edge k) updates the register at edge k+1. A read at edge k+1 still returns the old value, and a read at edge k+2 returns the new one.
- R4: For address a, the writable bits are `16'hFFFF >> (a mod 8)`. The remaining upper bits are reserved: they read as zero, and values written to them are ignored.
- R5: Addresses 74 to 127 are unmapped. They read as zero and ignore writes from either writer.
- R6: A calibration write (`cal_we` at edge k) updates its register at edge k+1, under the same bit masking. If a user write is accepted at the same edge, the calibration write proceeds, the user write is parked, and the ready flag is low after that edge. A read in between returns the calibration value.
- R7: A user write presented at an edge where the ready flag is low is discarded and never changes any register.
- R8: The parked write is replayed at the first edge with `cal_we` low and no calibration write still pending. The ready flag is high after that edge, and the register takes the parked value one edge later, overwriting a calibration value at the same address.
- R9: The holding store has one entry, and its content stays unchanged from the moment it is parked until it is replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_sel | input | 1 | User access select |
| usr_we | input | 1 | User write enable (with select) |
| usr_addr | input | 7 | User register address |
| usr_wdata | input | 16 | User write data |
| usr_rdata | output | 16 | Registered read data |
| usr_rdy | output | 1 | Ready flag; user writes are accepted only when high |
| cal_we | input | 1 | Calibration engine write request |
| cal_addr | input | 7 | Calibration write address |
| cal_wdata | input | 16 | Calibration write data |

## Verification
The assertions rely on the calibration engine never needing back-pressure: it may write on any edge, including back-to-back edges. The user side relies on `usr_addr` being a plain binary address, with unmapped values allowed. The stimulus drives all inputs half a cycle away from the active edge. It includes user writes issued while the flag is low and simultaneous writes to the same address. It holds `cal_we` for several consecutive edges, so the replay-gating condition is exercised with a pending calibration write.

// File: rtl/regport_pkg.sv
`timescale 1ns/1ps
package regport_pkg;
    parameter int unsigned RP_DATA_W   = 16;
    parameter int unsigned RP_ADDR_W   = 7;
    parameter int unsigned RP_MASK_SEL = 3;

    typedef logic [RP_DATA_W-1:0] word_t;
    typedef logic [RP_ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t addr;
        word_t data;
    } wr_req_t;

    // Writable-bit mask: the top (low-address-bits) positions are reserved.
    function automatic word_t mask_of(input logic [RP_MASK_SEL-1:0] sel);
        word_t ones;
        ones = '1;
        return ones >> sel;
    endfunction
endpackage

// File: rtl/rp_write_arb.sv
`timescale 1ns/1ps
module rp_write_arb
    import regport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    usr_wr,
    input  wr_req_t usr_req,
    input  logic    cal_wr,
    input  wr_req_t cal_req,
    output logic    commit_v,
    output wr_req_t commit_req,
    output logic    rdy
);
    logic    u_stage_v, c_stage_v, park_v, rdy_q;
    wr_req_t u_stage, c_stage, park_q;
    logic    usr_take, collide, replay_go;

    always_comb begin
        usr_take  = usr_wr && rdy_q;
        collide   = usr_take && cal_wr;
        replay_go = park_v && !cal_wr && !c_stage_v;
    end

    // Calibration pipeline stage: always advances.
    always_ff @(posedge clk) begin
        if (rst) begin
            c_stage_v <= 1'b0;
            c_stage   <= '0;
        end else begin
            c_stage_v <= cal_wr;
            if (cal_wr) c_stage <= cal_req;
        end
    end

    // User pipeline stage: fresh accepted write or replay of the parked one.
    always_ff @(posedge clk) begin
        if (rst) begin
            u_stage_v <= 1'b0;
            u_stage   <= '0;
        end else begin
            u_stage_v <= (usr_take && !cal_wr) || replay_go;
            if (replay_go)      u_stage <= park_q;
            else if (usr_take)  u_stage <= usr_req;
        end
    end

    // Single-entry holding store and ready flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            park_v <= 1'b0;
            park_q <= '0;
            rdy_q  <= 1'b1;
        end else if (collide) begin
            park_v <= 1'b1;
            park_q <= usr_req;
            rdy_q  <= 1'b0;
        end else if (replay_go) begin
            park_v <= 1'b0;
            rdy_q  <= 1'b1;
        end
    end

    always_comb begin
        commit_v   = c_stage_v || u_stage_v;
        commit_req = c_stage_v ? c_stage : u_stage;
        rdy        = rdy_q;
    end

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(c_stage_v && u_stage_v)); // R6
    AST_PARK_HELD: assert property (@(posedge clk) disable iff (rst)
        park_v |=> (!park_v || $stable(park_q))); // R9
    AST_DROP_LOW: assert property (@(posedge clk) disable iff (rst)
        (usr_wr && !rdy_q && !replay_go) |=> !u_stage_v); // R7
    AST_REPLAY_RDY: assert property (@(posedge clk) disable iff (rst)
        replay_go |=> (rdy_q && u_stage_v && !park_v)); // R8
    AST_COLLIDE_LOW: assert property (@(posedge clk) disable iff (rst)
        collide |=> (!rdy_q && park_v && c_stage_v)); // R6
endmodule

// File: rtl/rp_reg_bank.sv
`timescale 1ns/1ps
module rp_reg_bank
    import regport_pkg::*;
#(
    parameter int unsigned NUM_REGS = 74
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_v,
    input  wr_req_t wr_req,
    input  logic    rd_en,
    input  addr_t   rd_addr,
    output word_t   rdata
);
    localparam addr_t LAST_ADDR = addr_t'(NUM_REGS - 1);

    word_t regs_q [NUM_REGS];
    word_t rd_word;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam word_t WMASK = mask_of(RP_MASK_SEL'(i));
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_v && wr_req.addr == addr_t'(i))
                regs_q[i] <= wr_req.data & WMASK;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int j = 0; j < NUM_REGS; j++) begin
            if (rd_addr == addr_t'(j)) rd_word = regs_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_word;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr > LAST_ADDR) |=> (rdata == '0)); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ((rdata & ~mask_of($past(rd_addr[RP_MASK_SEL-1:0]))) == '0)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R2
endmodule

// File: rtl/rp_reg_port.sv
`timescale 1ns/1ps
module rp_reg_port
    import regport_pkg::*;
#(
    parameter int unsigned NUM_REGS = 74
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 usr_sel,
    input  logic                 usr_we,
    input  logic [RP_ADDR_W-1:0] usr_addr,
    input  logic [RP_DATA_W-1:0] usr_wdata,
    output logic [RP_DATA_W-1:0] usr_rdata,
    output logic                 usr_rdy,
    input  logic                 cal_we,
    input  logic [RP_ADDR_W-1:0] cal_addr,
    input  logic [RP_DATA_W-1:0] cal_wdata
);
    wr_req_t usr_req, cal_req, commit_req;
    logic    usr_wr, usr_rd, commit_v;

    always_comb begin
        usr_wr       = usr_sel && usr_we;
        usr_rd       = usr_sel && !usr_we;
        usr_req.addr = usr_addr;
        usr_req.data = usr_wdata;
        cal_req.addr = cal_addr;
        cal_req.data = cal_wdata;
    end

    rp_write_arb arb_i (
        .clk        (clk),
        .rst        (rst),
        .usr_wr     (usr_wr),
        .usr_req    (usr_req),
        .cal_wr     (cal_we),
        .cal_req    (cal_req),
        .commit_v   (commit_v),
        .commit_req (commit_req),
        .rdy        (usr_rdy)
    );

    rp_reg_bank #(.NUM_REGS(NUM_REGS)) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_v    (commit_v),
        .wr_req  (commit_req),
        .rd_en   (usr_rd),
        .rd_addr (usr_addr),
        .rdata   (usr_rdata)
    );

    AST_RST_RDY: assert property (@(posedge clk)
        rst |=> usr_rdy); // R1
endmodule

// File: tb/rp_reg_port_tb_top.sv
`timescale 1ns/1ps
module rp_reg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        usr_sel, usr_we, cal_we;
    logic [6:0]  usr_addr, cal_addr;
    logic [15:0] usr_wdata, cal_wdata, usr_rdata;
    logic        usr_rdy;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    rp_reg_port dut_i (
        .clk(clk), .rst(rst),
        .usr_sel(usr_sel), .usr_we(usr_we), .usr_addr(usr_addr),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_rdy(usr_rdy),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_wdata(cal_wdata)
    );

    function automatic logic [15:0] expect_val(input int a, input logic [15:0] d);
        if (a >= 74) return 16'h0000;
        return d & (16'hFFFF >> (a % 8));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic usr_write(input int a, input logic [15:0] d);
        usr_sel = 1; usr_we = 1; usr_addr = 7'(a); usr_wdata = d;
        @(negedge clk);
        usr_sel = 0; usr_we = 0;
        @(negedge clk);
    endtask

    task automatic usr_read(input int a, output logic [15:0] d);
        usr_sel = 1; usr_we = 0; usr_addr = 7'(a);
        @(negedge clk);
        usr_sel = 0;
        d = usr_rdata;
    endtask

    task automatic cal_write(input int a, input logic [15:0] d);
        cal_we = 1; cal_addr = 7'(a); cal_wdata = d;
        @(negedge clk);
        cal_we = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        usr_sel = 0; usr_we = 0; usr_addr = 0; usr_wdata = 0;
        cal_we = 0; cal_addr = 0; cal_wdata = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 rdy", {15'h0, usr_rdy}, 16'h1);
        check("R1 rdata", usr_rdata, 16'h0);
        for (int a = 0; a < 74; a++) begin
            usr_read(a, rd);
            check("R1 reg", rd, 16'h0);
        end
        // R4, R5: write every address with a pattern and read back
        for (int a = 0; a < 128; a++) usr_write(a, 16'hFFFF ^ 16'(a * 16'h0101));
        for (int a = 0; a < 128; a++) begin
            usr_read(a, rd);
            if (a >= 74) check("R5 unmapped", rd, 16'h0);
            else check("R4 mask", rd, expect_val(a, 16'hFFFF ^ 16'(a * 16'h0101)));
        end
        // R2: rdata holds without a read
        usr_read(6, rd);
        @(negedge clk); @(negedge clk);
        check("R2 hold", usr_rdata, expect_val(6, 16'hFFFF ^ 16'(6 * 16'h0101)));
        // R3: write latency
        usr_write(5, 16'h0000);
        usr_sel = 1; usr_we = 1; usr_addr = 7'd5; usr_wdata = 16'h1234;
        @(negedge clk);
        usr_we = 0;
        @(negedge clk);
        check("R3 old at k+1", usr_rdata, 16'h0000);
        @(negedge clk);
        usr_sel = 0;
        check("R3 new at k+2", usr_rdata, expect_val(5, 16'h1234));
        // R6, R5: calibration writes masked
        cal_write(3, 16'hFFFF);
        usr_read(3, rd);
        check("R6 cal masked", rd, 16'h1FFF);
        cal_write(100, 16'hFFFF);
        usr_read(100, rd);
        check("R5 cal unmapped", rd, 16'h0);
        // R6, R7, R8: collision with multi-cycle calibration burst
        usr_write(16, 16'h0F0F);
        usr_sel = 1; usr_we = 1; usr_addr = 7'd8; usr_wdata = 16'hA5A5;
        cal_we = 1; cal_addr = 7'd9; cal_wdata = 16'h1111;
        @(negedge clk);
        check("R6 rdy low", {15'h0, usr_rdy}, 16'h0);
        usr_addr = 7'd16; usr_wdata = 16'hBEEF;
        cal_addr = 7'd10; cal_wdata = 16'h2222;
        @(negedge clk);
        usr_sel = 0; usr_we = 0;
        check("R7 rdy low", {15'h0, usr_rdy}, 16'h0);
        cal_addr = 7'd11; cal_wdata = 16'h3333;
        @(negedge clk);
        cal_we = 0;
        check("R8 rdy low in burst", {15'h0, usr_rdy}, 16'h0);
        @(negedge clk);
        check("R8 rdy low pending", {15'h0, usr_rdy}, 16'h0);
        @(negedge clk);
        check("R8 rdy high", {15'h1 & 15'h0, usr_rdy}, 16'h1);
        @(negedge clk);
        usr_read(8, rd);  check("R8 replayed", rd, 16'hA5A5);
        usr_read(9, rd);  check("R6 cal a", rd, 16'h1111);
        usr_read(10, rd); check("R6 cal b", rd, 16'h2222);
        usr_read(11, rd); check("R6 cal c", rd, 16'h1333 & 16'h1FFF | 16'h0000);
        usr_read(16, rd); check("R7 dropped", rd, 16'h0F0F);
        // R6, R8, R9: same-address collision
        usr_write(12, 16'h0000);
        usr_sel = 1; usr_we = 1; usr_addr = 7'd12; usr_wdata = 16'h0ABC;
        cal_we = 1; cal_addr = 7'd12; cal_wdata = 16'h0123;
        @(negedge clk);
        usr_sel = 0; usr_we = 0; cal_we = 0;
        @(negedge clk);
        usr_sel = 1; usr_we = 0; usr_addr = 7'd12;
        @(negedge clk);
        usr_sel = 0;
        check("R6 cal wins", usr_rdata, 16'h0123);
        check("R8 rdy back", {15'h0, usr_rdy}, 16'h1);
        @(negedge clk);
        usr_read(12, rd);
        check("R9 parked value", rd, 16'h0ABC);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule